// File: doc/BRIEF.md
# Beam Pattern Lookahead Pipeline

This block delays each scheduled beam pattern so that it is presented three fiducials before the pulse it describes. Each word carries a 128-bit pattern and an 8-bit beam code. It arrives on a valid/ready stream and waits in a single holding slot until the next fiducial strobe. The strobe then moves it into the head of a three-stage lookahead pipeline. The pipeline moves one stage on every fiducial. When a word leaves the last lookahead stage it becomes the "due now" pattern. At that point it is stamped with the state of the containment fault input and a pulse identifier.

Every word is widened to 192 bits inside the block. Protection (permit) information is merged into the word. Normally the latest protection word is written into the word as it enters the head. A bypass request instead rewrites the protection field of a word already part-way down the pipeline. This gives protection data that arrives late a near-real-time effect without waiting three fiducials.

Both streams follow these rules:

- **Input.** The input stream accepts at most one word per fiducial. `sched_ready_o` stays low from acceptance until the fiducial that consumes the word.
- **Output.** The due-now output is a valid-only stream. It has no back-pressure, because the fiducial rate cannot be stalled.

Extended word layout:

| Bits | Content |
|------|---------|
| 127:0 | scheduled pattern |
| 135:128 | beam code |
| 151:136 | protection word |
| 152 | bypass-written tag |
| 153 | containment fault |
| 154 | underrun tag |
| 159:155 | zero |
| 191:160 | pulse identifier, zero-extended; zero while the word is in a lookahead stage |

Top module: `beam_lookahead_pipe`

## Requirements
- R1: After reset all lookahead stages and `now_pat_o` are zero, `now_pid_o` is 0, `ahead_full_o` and `now_valid_o` are low and `sched_ready_o` is high.
- R2: `sched_ready_o` is high exactly when no word is held. A word accepted (`sched_valid_i` and `sched_ready_o` high at a clock edge) drops ready until the next fiducial edge. A word accepted at the same edge as a fiducial is held for the following fiducial. A word offered while ready is low is not taken.
- R3: At a fiducial edge the held word enters stage 0, with pattern in bits 127:0 and code in bits 135:128. Stage k takes the old stage k-1. Stage 0 is three fiducials ahead of its pulse.
- R4: At a fiducial with no held word, stage 0 receives a zero pattern and code with bit 154 set.
- R5: A normal protection update (`prot_valid_i` high, `prot_bypass_i` low) is latched. The latched word fills bits 151:136 of each word entering stage 0. An update at the same edge as a fiducial is used by that fiducial's head word.
- R6: A bypass update (`prot_valid_i` and `prot_bypass_i` high) without a fiducial overwrites bits 151:136 of stage `BYP_STAGE` (default 1) and sets its bit 152. It leaves the latched normal word unchanged.
- R7: A bypass update at the same edge as a fiducial lands in stage `BYP_STAGE`+1, overriding the value shifted into it.
- R8: At each fiducial the last lookahead stage moves into `now_pat_o`. Bit 153 is set when `bcs_fault_i` is high at that edge.
- R9: `now_pid_o` increments by one (wrapping) on every fiducial. The same value is zero-extended into bits 191:160 of `now_pat_o`.
- R10: `ahead_full_o` rises at the third fiducial after reset and stays high. `now_valid_o` is a one-cycle pulse after each fiducial at which `ahead_full_o` was already high.
- R11: Without a fiducial or a bypass update, all lookahead stages hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| fid_i | input | 1 | fiducial strobe, one cycle per pulse |
| sched_valid_i | input | 1 | scheduled word valid |
| sched_ready_o | output | 1 | holding slot empty |
| sched_pat_i | input | 128 | scheduled beam pattern |
| sched_code_i | input | 8 | beam code |
| prot_valid_i | input | 1 | protection word strobe |
| prot_bypass_i | input | 1 | write protection word into a later stage |
| prot_word_i | input | 16 | protection / permit word |
| bcs_fault_i | input | 1 | hardwired containment fault level |
| ahead_pat_o | output | 576 | lookahead stages, stage k at bits k*192 upward |
| ahead_full_o | output | 1 | all lookahead stages filled since reset |
| now_valid_o | output | 1 | due-now pattern valid pulse |
| now_pat_o | output | 192 | pattern due at this fiducial |
| now_pid_o | output | 17 | pulse identifier |

## Verification
All registered results appear one rising edge after the stimulus that causes them:

- At that edge the stage contents, `now_pat_o`, `now_pid_o`, `ahead_full_o` and `sched_ready_o` take their new values. `now_valid_o` pulses for the single cycle that follows a fiducial edge.
- A bypass without a fiducial shows in stage `BYP_STAGE` after one edge. A protection update reaches the head only at the next fiducial edge.

The driver applies inputs on the falling edge and updates its expected model for the coming rising edge. All checks sample at the next falling edge. A monitor pops expected due-now words from the scoreboard queue only on cycles where `now_valid_o` is high.

// File: rtl/blp_pkg.sv
package blp_pkg;
  localparam int PAT_W     = 128;
  localparam int CODE_W    = 8;
  localparam int PROT_W    = 16;
  localparam int EXT_W     = 192;
  localparam int CODE_LSB  = PAT_W;
  localparam int PROT_LSB  = CODE_LSB + CODE_W;
  localparam int BYP_BIT   = PROT_LSB + PROT_W;
  localparam int FAULT_BIT = BYP_BIT + 1;
  localparam int UNDER_BIT = BYP_BIT + 2;
  localparam int PID_LSB   = 160;
  localparam int PID_FLD_W = EXT_W - PID_LSB;

  typedef logic [EXT_W-1:0] ext_word_t;

  function automatic ext_word_t build_head(input logic [PAT_W-1:0] pat,
                                           input logic [CODE_W-1:0] code,
                                           input logic [PROT_W-1:0] prot,
                                           input logic under);
    ext_word_t w;
    w = '0;
    w[PAT_W-1:0]               = pat;
    w[CODE_LSB +: CODE_W]      = code;
    w[PROT_LSB +: PROT_W]      = prot;
    w[UNDER_BIT]               = under;
    return w;
  endfunction
endpackage

// File: rtl/blp_ingress.sv
module blp_ingress
  import blp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fid_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [PAT_W-1:0]  in_pat_i,
  input  logic [CODE_W-1:0] in_code_i,
  output logic              held_full_o,
  output logic [PAT_W-1:0]  held_pat_o,
  output logic [CODE_W-1:0] held_code_o
);
  logic              full_q;
  logic [PAT_W-1:0]  pat_q;
  logic [CODE_W-1:0] code_q;
  logic              take;

  assign in_ready_o  = !full_q;
  assign take        = in_valid_i && !full_q;
  assign held_full_o = full_q;
  assign held_pat_o  = pat_q;
  assign held_code_o = code_q;

  // The slot is consumed by a fiducial; a word taken on that same edge refills it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      pat_q  <= '0;
      code_q <= '0;
    end else begin
      if (take) begin
        pat_q  <= in_pat_i;
        code_q <= in_code_i;
      end
      if (fid_i)     full_q <= take;
      else if (take) full_q <= 1'b1;
    end
  end

  p_one_per_fid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && !fid_i) |=> !in_ready_o);
endmodule

// File: rtl/blp_prot_latch.sv
module blp_prot_latch
  import blp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_valid_i,
  input  logic              prot_bypass_i,
  input  logic [PROT_W-1:0] prot_word_i,
  output logic [PROT_W-1:0] norm_word_o,
  output logic              byp_we_o,
  output logic [PROT_W-1:0] byp_word_o
);
  logic [PROT_W-1:0] prot_q;
  logic              norm_upd;

  assign norm_upd    = prot_valid_i && !prot_bypass_i;
  // Forward a same-cycle update so the head word never misses it.
  assign norm_word_o = norm_upd ? prot_word_i : prot_q;
  assign byp_we_o    = prot_valid_i && prot_bypass_i;
  assign byp_word_o  = prot_word_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prot_q <= '0;
    else if (norm_upd) prot_q <= prot_word_i;
  end
endmodule

// File: rtl/blp_stages.sv
module blp_stages
  import blp_pkg::*;
#(
  parameter int DEPTH     = 3,
  parameter int BYP_STAGE = 1,   // 1 .. DEPTH-1
  parameter int PID_W     = 17   // <= 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fid_i,
  input  ext_word_t              head_i,
  input  logic                   byp_we_i,
  input  logic [PROT_W-1:0]      byp_word_i,
  input  logic                   fault_i,
  input  logic [PID_W-1:0]       pid_q_i,
  output logic [DEPTH*EXT_W-1:0] ahead_o,
  output ext_word_t              now_o
);
  localparam int TGT_IDLE  = BYP_STAGE;
  localparam int TGT_SHIFT = BYP_STAGE + 1;

  ext_word_t        st [DEPTH+1];
  logic [PID_W-1:0] pid_inc;

  assign pid_inc = pid_q_i + PID_W'(1);

  for (genvar k = 0; k <= DEPTH; k++) begin : g_stage
    ext_word_t shifted;
    ext_word_t nxt;

    if (k == 0) begin : g_head
      assign shifted = head_i;
    end else if (k < DEPTH) begin : g_mid
      assign shifted = st[k-1];
    end else begin : g_now
      always_comb begin
        shifted                       = st[k-1];
        shifted[FAULT_BIT]            = fault_i;
        shifted[PID_LSB +: PID_FLD_W] = PID_FLD_W'(pid_inc);
      end
    end

    always_comb begin
      nxt = fid_i ? shifted : st[k];
      // The bypass follows the word it targets when that word moves this cycle.
      if (byp_we_i && (k == (fid_i ? TGT_SHIFT : TGT_IDLE))) begin
        nxt[PROT_LSB +: PROT_W] = byp_word_i;
        nxt[BYP_BIT]            = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[k] <= '0;
      else        st[k] <= nxt;
    end

    if (k < DEPTH) begin : g_out
      assign ahead_o[k*EXT_W +: EXT_W] = st[k];
    end
  end

  assign now_o = st[DEPTH];

  p_bypass_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_we_i && !fid_i) |=>
      (st[BYP_STAGE][PROT_LSB +: PROT_W] == $past(byp_word_i)) && st[BYP_STAGE][BYP_BIT]);

  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fid_i && !byp_we_i) |=> (st[1] == $past(st[0])));
endmodule

// File: rtl/blp_track.sv
module blp_track #(
  parameter int DEPTH = 3,
  parameter int PID_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fid_i,
  output logic             full_o,
  output logic             now_valid_o,
  output logic [PID_W-1:0] pid_o
);
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [FILL_W-1:0] fill_q;
  logic              valid_q;
  logic [PID_W-1:0]  pid_q;

  assign full_o      = (fill_q == FILL_W'(DEPTH));
  assign now_valid_o = valid_q;
  assign pid_o       = pid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      valid_q <= 1'b0;
      pid_q   <= '0;
    end else begin
      valid_q <= fid_i && full_o;
      if (fid_i) begin
        pid_q <= pid_q + PID_W'(1);
        if (!full_o) fill_q <= fill_q + FILL_W'(1);
      end
    end
  end

  p_full_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> full_o);
  p_valid_after_fid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    now_valid_o |-> $past(fid_i));
  p_pid_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fid_i |=> (pid_o == $past(pid_o) + PID_W'(1)));
endmodule

// File: rtl/beam_lookahead_pipe.sv
module beam_lookahead_pipe
  import blp_pkg::*;
#(
  parameter int DEPTH     = 3,
  parameter int BYP_STAGE = 1,
  parameter int PID_W     = 17
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fid_i,
  input  logic                   sched_valid_i,
  output logic                   sched_ready_o,
  input  logic [PAT_W-1:0]       sched_pat_i,
  input  logic [CODE_W-1:0]      sched_code_i,
  input  logic                   prot_valid_i,
  input  logic                   prot_bypass_i,
  input  logic [PROT_W-1:0]      prot_word_i,
  input  logic                   bcs_fault_i,
  output logic [DEPTH*EXT_W-1:0] ahead_pat_o,
  output logic                   ahead_full_o,
  output logic                   now_valid_o,
  output logic [EXT_W-1:0]       now_pat_o,
  output logic [PID_W-1:0]       now_pid_o
);
  logic              held_full;
  logic [PAT_W-1:0]  held_pat;
  logic [CODE_W-1:0] held_code;
  logic [PROT_W-1:0] norm_word;
  logic              byp_we;
  logic [PROT_W-1:0] byp_word;
  ext_word_t         head_word;

  blp_ingress u_ingress (
    .clk(clk), .rst_n(rst_n), .fid_i(fid_i),
    .in_valid_i(sched_valid_i), .in_ready_o(sched_ready_o),
    .in_pat_i(sched_pat_i), .in_code_i(sched_code_i),
    .held_full_o(held_full), .held_pat_o(held_pat), .held_code_o(held_code)
  );

  blp_prot_latch u_prot (
    .clk(clk), .rst_n(rst_n),
    .prot_valid_i(prot_valid_i), .prot_bypass_i(prot_bypass_i), .prot_word_i(prot_word_i),
    .norm_word_o(norm_word), .byp_we_o(byp_we), .byp_word_o(byp_word)
  );

  assign head_word = build_head(held_full ? held_pat : '0,
                                held_full ? held_code : '0,
                                norm_word, !held_full);

  blp_stages #(.DEPTH(DEPTH), .BYP_STAGE(BYP_STAGE), .PID_W(PID_W)) u_stages (
    .clk(clk), .rst_n(rst_n), .fid_i(fid_i), .head_i(head_word),
    .byp_we_i(byp_we), .byp_word_i(byp_word), .fault_i(bcs_fault_i),
    .pid_q_i(now_pid_o), .ahead_o(ahead_pat_o), .now_o(now_pat_o)
  );

  blp_track #(.DEPTH(DEPTH), .PID_W(PID_W)) u_track (
    .clk(clk), .rst_n(rst_n), .fid_i(fid_i),
    .full_o(ahead_full_o), .now_valid_o(now_valid_o), .pid_o(now_pid_o)
  );

  p_fault_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fid_i && bcs_fault_i) |=> now_pat_o[FAULT_BIT]);
  p_pid_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fid_i |=> (now_pat_o[PID_LSB +: PID_W] == now_pid_o));
  p_underrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fid_i && sched_ready_o) |=> ahead_pat_o[UNDER_BIT]);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fid_i && !(prot_valid_i && prot_bypass_i)) |=> $stable(ahead_pat_o));
endmodule

// File: tb/tb_beam_lookahead_pipe.sv
module tb_beam_lookahead_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 3;
  localparam int BYP = 1;
  localparam int PW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fid_i = 1'b0, sched_valid_i = 1'b0, prot_valid_i = 1'b0, prot_bypass_i = 1'b0, bcs_fault_i = 1'b0;
  logic [127:0] sched_pat_i = '0;
  logic [7:0]   sched_code_i = '0;
  logic [15:0]  prot_word_i = '0;
  logic sched_ready_o, ahead_full_o, now_valid_o;
  logic [DEPTH*192-1:0] ahead_pat_o;
  logic [191:0] now_pat_o;
  logic [PW-1:0] now_pid_o;

  int n_chk = 0, n_bad = 0;
  logic [191:0] m [DEPTH+1];
  logic [191:0] expq [$];
  logic [PW-1:0] mpid = '0;
  int mfill = 0;
  logic [15:0] mprot = '0;
  bit mheld = 0;
  logic [127:0] mhp = '0;
  logic [7:0] mhc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beam_lookahead_pipe dut (
    .clk(clk), .rst_n(rst_n), .fid_i(fid_i), .sched_valid_i(sched_valid_i),
    .sched_ready_o(sched_ready_o), .sched_pat_i(sched_pat_i), .sched_code_i(sched_code_i),
    .prot_valid_i(prot_valid_i), .prot_bypass_i(prot_bypass_i), .prot_word_i(prot_word_i),
    .bcs_fault_i(bcs_fault_i), .ahead_pat_o(ahead_pat_o), .ahead_full_o(ahead_full_o),
    .now_valid_o(now_valid_o), .now_pat_o(now_pat_o), .now_pid_o(now_pid_o)
  );

  task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [191:0] mk(input logic [127:0] p, input logic [7:0] c,
                                       input logic [15:0] pr, input logic u);
    logic [191:0] w;
    w = '0; w[127:0] = p; w[135:128] = c; w[151:136] = pr; w[154] = u;
    return w;
  endfunction

  // Scoreboard monitor: each due-now pulse must match the oldest expected word.
  always @(negedge clk) begin
    if (rst_n && now_valid_o) begin
      if (expq.size() == 0) chk("R10 unexpected now_valid", 192'd1, 192'd0);
      else begin
        logic [191:0] e;
        e = expq.pop_front();
        chk("R8 due-now pattern", now_pat_o, e);
        chk("R9 pulse id", {175'd0, now_pid_o}, {175'd0, e[160 +: PW]});
      end
    end
  end

  // Driver: applies one cycle of stimulus and advances the expected model.
  task automatic drive(input bit f, input bit s, input logic [127:0] p, input logic [7:0] c,
                       input bit pv, input bit pb, input logic [15:0] w, input bit flt);
    bit acc;
    logic [15:0] nw;
    logic [191:0] dep;
    fid_i = f; sched_valid_i = s; sched_pat_i = p; sched_code_i = c;
    prot_valid_i = pv; prot_bypass_i = pb; prot_word_i = w; bcs_fault_i = flt;
    acc = s && !mheld;
    nw = (pv && !pb) ? w : mprot;
    if (f) begin
      dep = m[DEPTH-1];
      dep[153] = flt;
      dep[191:160] = 32'(mpid + PW'(1));
      if (mfill == DEPTH) expq.push_back(dep);
      m[DEPTH] = dep;
      for (int k = DEPTH-1; k > 0; k--) m[k] = m[k-1];
      m[0] = mheld ? mk(mhp, mhc, nw, 1'b0) : mk('0, '0, nw, 1'b1);
      mpid = mpid + PW'(1);
      if (mfill < DEPTH) mfill++;
      if (pv && pb) begin m[BYP+1][151:136] = w; m[BYP+1][152] = 1'b1; end
      mheld = acc;
    end else begin
      if (pv && pb) begin m[BYP][151:136] = w; m[BYP][152] = 1'b1; end
      if (acc) mheld = 1;
    end
    if (acc) begin mhp = p; mhc = c; end
    if (pv && !pb) mprot = w;
    @(negedge clk);
    fid_i = 0; sched_valid_i = 0; prot_valid_i = 0; prot_bypass_i = 0; bcs_fault_i = 0;
    chk("R2 ready", {191'd0, sched_ready_o}, {191'd0, !mheld});
    for (int k = 0; k < DEPTH; k++) chk("R3 lookahead stage", ahead_pat_o[k*192 +: 192], m[k]);
    chk("R8 now register", now_pat_o, m[DEPTH]);
    chk("R9 pid", {175'd0, now_pid_o}, {175'd0, mpid});
    chk("R10 full flag", {191'd0, ahead_full_o}, {191'd0, mfill == DEPTH});
  endtask

  task automatic idle();
    drive(0, 0, '0, '0, 0, 0, '0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DEPTH*192-1:0] snap;
    for (int k = 0; k <= DEPTH; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ahead zero", ahead_pat_o[191:0] | ahead_pat_o[383:192] | ahead_pat_o[575:384], '0);
    chk("R1 now zero", now_pat_o, '0);
    chk("R1 flags", {188'd0, sched_ready_o, ahead_full_o, now_valid_o, |now_pid_o}, {188'd0, 4'b1000});
    rst_n = 1'b1;
    @(negedge clk);

    drive(0, 1, 128'hA5A5_0000_1111_2222_3333_4444_5555_6666, 8'h11, 0, 0, '0, 0);
    chk("R2 ready low after accept", {191'd0, sched_ready_o}, 192'd0);
    drive(0, 1, 128'hDEAD, 8'h77, 1, 0, 16'h1111, 0);   // blocked offer, normal prot
    drive(1, 0, '0, '0, 0, 0, '0, 0);
    chk("R5 head protection", {176'd0, ahead_pat_o[151:136]}, {176'd0, 16'h1111});
    chk("R2 blocked word not taken", {64'd0, ahead_pat_o[127:0]}, {64'd0, 128'hA5A5_0000_1111_2222_3333_4444_5555_6666});
    drive(1, 0, '0, '0, 0, 0, '0, 0);
    chk("R4 underrun tag", {191'd0, ahead_pat_o[154]}, 192'd1);
    drive(0, 0, '0, '0, 1, 1, 16'hB0B0, 0);
    chk("R6 bypass into stage", {176'd0, ahead_pat_o[192+136 +: 16]}, {176'd0, 16'hB0B0});
    drive(1, 1, 128'hB2, 8'h22, 1, 1, 16'hC2C2, 0);
    chk("R7 bypass after shift", {175'd0, ahead_pat_o[384+152], ahead_pat_o[384+136 +: 16]}, {175'd0, 1'b1, 16'hC2C2});
    chk("R10 full after three", {191'd0, ahead_full_o}, 192'd1);
    snap = ahead_pat_o;
    idle(); idle();
    chk("R11 hold stage0", snap[191:0], ahead_pat_o[191:0]);
    chk("R11 hold stage2", snap[575:384], ahead_pat_o[575:384]);
    drive(1, 0, '0, '0, 0, 0, '0, 1);
    chk("R6 latched normal word kept", {176'd0, ahead_pat_o[151:136]}, {176'd0, 16'h1111});
    chk("R8 fault bit", {191'd0, now_pat_o[153]}, 192'd1);
    chk("R10 now_valid pulse", {191'd0, now_valid_o}, 192'd1);
    idle();
    chk("R10 now_valid one cycle", {191'd0, now_valid_o}, 192'd0);
    drive(1, 1, 128'hC3C3, 8'h33, 1, 0, 16'h2222, 0);
    chk("R5 same-cycle forward", {176'd0, ahead_pat_o[151:136]}, {176'd0, 16'h2222});
    drive(1, 0, '0, '0, 0, 0, '0, 0);
    for (int i = 0; i < 8; i++) begin
      drive(0, 1, {4{24'h5A0000 + 24'(i), 8'(i)}}, 8'(8'h40 + i), (i % 3) == 0, (i % 2) == 1, 16'(16'h3000 + i), 0);
      drive(1, 0, '0, '0, 0, 0, '0, (i % 2) == 0);
    end
    repeat (4) drive(1, 0, '0, '0, 0, 0, '0, 0);
    idle();
    chk("R10 scoreboard drained", {160'd0, 32'(expq.size())}, 192'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule